// File: doc/BRIEF.md
# Programmable 16-bit Interval Timer

This block is a 16-bit down-counter with a byte-wide register port. Software writes a reload value into a pair of byte latches and then controls the counter through a control register. The control register can start or halt counting and can select one-shot or free-running reload. It also picks the count source: every system clock, or rising edges on an external pin. A strobe bit copies the latch into the counter at once. Reading the two counter bytes gives the live count. Because the count falls, a full-scale preload gives the elapsed ticks as the bitwise inverse of the reading.

When the counter is at zero and a count event arrives, it underflows. It then reloads from the latch and sets a sticky interrupt flag. It can also drive a dedicated output pin, which either toggles or pulses high for one clock. An enable mask gates the flag onto the interrupt request output. Reading the status register clears the flag.

Top module: `interval_timer16`

## Requirements
- R1: After reset the counter and the latch hold 0xFFFF, the control register reads 0x00, and the output pin and the interrupt request are low.
- R2: Address 4 writes the low latch byte and address 5 writes the high latch byte. Address 14 is the control register and address 13 is the status/mask register. Reads of addresses 4 and 5 return the low and high bytes of the live counter.
- R3: With control bit 0 = 1 and bit 5 = 0, the counter falls by one on every clock. With bit 0 = 0 the counter holds its value.
- R4: On an underflow the counter reloads from the latch, so a free-running counter loaded with L underflows once every L+1 count events.
- R5: With control bit 3 = 1 (one-shot), the counter reloads at underflow and stops, and control bit 0 then reads back 0. With bit 3 = 0 it keeps running.
- R6: Writing control bit 4 = 1 copies the latch into the counter on that write. Bit 4 always reads back 0. Writing 0x19 loads the counter and starts a one-shot run in one access.
- R7: A write to the high latch byte while the timer is stopped also loads the counter from the full latch. The same write while the timer runs, or any low-byte write, leaves the counter alone.
- R8: With control bit 5 = 1 the counter falls once per rising edge of `cnt_in`, after a two-flop synchronizer. A level held high counts only once.
- R9: With control bit 1 = 1 and bit 2 = 0, `tmr_pin` inverts on every underflow. With bit 1 = 0, `tmr_pin` is low.
- R10: With control bits 1 and 2 both 1, `tmr_pin` is high for exactly the one cycle after each underflow.
- R11: Each underflow sets a sticky flag, read as status bit 0 at address 13. A read of address 13 clears it. Writing address 13 bit 0 sets the mask. `irq` = flag AND mask, and status bit 7 reads `irq`.
- R12: Control bits 6 and 7 are stored and read back but change no behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears flag) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, zero when not reading |
| cnt_in | input | 1 | External count input, asynchronous |
| tmr_pin | output | 1 | Underflow indication pin |
| irq | output | 1 | Masked interrupt request |

## Verification
A counter that is off by one shows up in the very next read of addresses 4/5, because the bench predicts every counter value from the reload value and the elapsed clocks. A wrong reload or a mode bit lost across underflow shifts the underflow phase. That appears within one period as a wrong pin level, a wrong flag bit or a wrong run bit. A bad synchronizer or edge detector changes how many external counts are taken, which shows in the count as soon as the pulse train ends.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] RA_LAT_LO = 4'd4;
    localparam logic [REG_AW-1:0] RA_LAT_HI = 4'd5;
    localparam logic [REG_AW-1:0] RA_STAT   = 4'd13;
    localparam logic [REG_AW-1:0] RA_CTRL   = 4'd14;

    // bit order is software visible
    typedef struct packed {
        logic [1:0] spare;
        logic       src_ext;
        logic       force_ld;
        logic       one_shot;
        logic       pulse_mode;
        logic       pin_en;
        logic       run;
    } tctrl_t;
endpackage

// File: rtl/itimer_edge_sync.sv
module itimer_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SH_W-2:0], din};
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/itimer_regs.sv
module itimer_regs
    import itimer_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int CNT_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              uflow,
    output logic              run,
    output logic              src_ext,
    output logic              pin_en,
    output logic              pulse_mode,
    output logic [CNT_W-1:0]  latch,
    output logic              load_req,
    output logic [CNT_W-1:0]  load_val,
    output logic              flag,
    output logic              mask,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [CNT_W-1:0] latch;
        tctrl_t           ctrl;
        logic             mask;
        logic             flag;
    } reg_st_t;

    reg_st_t d, q;
    tctrl_t  wr_c;
    logic    wr_lo, wr_hi, wr_ctl, wr_st, rd_st;

    always_comb begin
        wr_c   = tctrl_t'(wdata);
        wr_lo  = wr_en && (addr == RA_LAT_LO);
        wr_hi  = wr_en && (addr == RA_LAT_HI);
        wr_ctl = wr_en && (addr == RA_CTRL);
        wr_st  = wr_en && (addr == RA_STAT);
        rd_st  = rd_en && (addr == RA_STAT);

        d = q;
        if (wr_lo) d.latch[DATA_W-1:0]     = wdata;
        if (wr_hi) d.latch[CNT_W-1:DATA_W] = wdata;
        if (wr_ctl) begin
            d.ctrl          = wr_c;
            d.ctrl.force_ld = 1'b0;
        end else if (uflow && q.ctrl.one_shot) begin
            d.ctrl.run = 1'b0;
        end
        if (wr_st) d.mask = wdata[0];
        d.flag = (q.flag & ~rd_st) | uflow;

        load_req = (wr_ctl && wr_c.force_ld) || (wr_hi && !q.ctrl.run);
        load_val = wr_hi ? {wdata, q.latch[DATA_W-1:0]} : q.latch;

        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                RA_LAT_LO: rdata = cnt[DATA_W-1:0];
                RA_LAT_HI: rdata = cnt[CNT_W-1:DATA_W];
                RA_STAT:   rdata = {q.flag & q.mask, {(DATA_W-2){1'b0}}, q.flag};
                RA_CTRL:   rdata = q.ctrl;
                default:   rdata = '0;
            endcase
        end

        run        = q.ctrl.run;
        src_ext    = q.ctrl.src_ext;
        pin_en     = q.ctrl.pin_en;
        pulse_mode = q.ctrl.pulse_mode;
        latch      = q.latch;
        flag       = q.flag;
        mask       = q.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.latch <= '1;
            q.ctrl  <= '0;
            q.mask  <= 1'b0;
            q.flag  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/itimer_core.sv
module itimer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_ext,
    input  logic             ext_rise,
    input  logic             pin_en,
    input  logic             pulse_mode,
    input  logic             load_req,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] latch,
    output logic [CNT_W-1:0] cnt,
    output logic             uflow,
    output logic             pin
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tgl;
        logic             pls;
    } core_st_t;

    core_st_t d, q;
    logic     tick;

    always_comb begin
        tick  = run && (src_ext ? ext_rise : 1'b1);
        uflow = tick && (q.cnt == '0) && !load_req;

        d     = q;
        if (load_req)   d.cnt = load_val;
        else if (uflow) d.cnt = latch;
        else if (tick)  d.cnt = q.cnt - 1'b1;
        d.tgl = q.tgl ^ uflow;
        d.pls = uflow;

        cnt = q.cnt;
        pin = pin_en && (pulse_mode ? q.pls : q.tgl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= '1;
            q.tgl <= 1'b0;
            q.pls <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/interval_timer16.sv
module interval_timer16
    import itimer_pkg::*;
#(
    parameter int DATA_W      = BYTE_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_in,
    output logic              tmr_pin,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic             run_w, src_w, pin_en_w, pulse_w;
    logic             load_w, uflow_w, rise_w, flag_w, mask_w;
    logic [CNT_W-1:0] latch_w, load_val_w, cnt_w;

    itimer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cnt_in),
        .rise (rise_w)
    );

    itimer_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cnt       (cnt_w),
        .uflow     (uflow_w),
        .run       (run_w),
        .src_ext   (src_w),
        .pin_en    (pin_en_w),
        .pulse_mode(pulse_w),
        .latch     (latch_w),
        .load_req  (load_w),
        .load_val  (load_val_w),
        .flag      (flag_w),
        .mask      (mask_w),
        .rdata     (bus_rdata)
    );

    itimer_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .src_ext   (src_w),
        .ext_rise  (rise_w),
        .pin_en    (pin_en_w),
        .pulse_mode(pulse_w),
        .load_req  (load_w),
        .load_val  (load_val_w),
        .latch     (latch_w),
        .cnt       (cnt_w),
        .uflow     (uflow_w),
        .pin       (tmr_pin)
    );

    assign irq = flag_w & mask_w;
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] latch,
    input logic             uflow,
    input logic             load,
    input logic             run,
    input logic             src_ext,
    input logic             pin_en,
    input logic             pulse_mode,
    input logic             tmr_pin,
    input logic             flag
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !src_ext && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt)); // R3
    AST_NO_UFLOW_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !uflow); // R3
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (uflow && !load) |=> (cnt == $past(latch))); // R4
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> flag); // R11
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en && pulse_mode && tmr_pin && !uflow) |=>
        (!tmr_pin || !$stable(pulse_mode) || !$stable(pin_en))); // R10
endmodule

bind interval_timer16 itimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_w),
    .latch     (latch_w),
    .uflow     (uflow_w),
    .load      (load_w),
    .run       (run_w),
    .src_ext   (src_w),
    .pin_en    (pin_en_w),
    .pulse_mode(pulse_w),
    .tmr_pin   (tmr_pin),
    .flag      (flag_w)
);

// File: tb/tb_interval_timer16.sv
module tb_interval_timer16;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, cnt_in = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    wire  [7:0] bus_rdata;
    wire        tmr_pin, irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    interval_timer16 dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_in(cnt_in), .tmr_pin(tmr_pin), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_clr();
        bus_rd = 1'b1; bus_addr = 4'd13;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(4'd4, lo);
        rd(4'd5, hi);
        v = {hi, lo};
    endtask

    function automatic int exp_uf(input int l, input int n, input bit os);
        int u = n / (l + 1);
        return (os && u > 1) ? 1 : u;
    endfunction

    function automatic logic [15:0] exp_cnt(input int l, input int n, input bit os);
        if (os) return (n <= l) ? 16'(l - n) : 16'(l);
        return 16'(l - (n % (l + 1)));
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  r;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_cnt(c);          chk("R1 count", c, 16'hFFFF);
        rd(4'd14, r);       chk("R1 ctrl", 16'(r), 16'h00);
        chk("R1 pin", 16'(tmr_pin), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);

        // R7 high-byte write while stopped loads
        wr(4'd4, 8'd100); wr(4'd5, 8'd0);
        rd_cnt(c);          chk("R7 load stopped", c, 16'd100);
        wr(4'd14, 8'h01);                    // start, no tick on this edge
        wr(4'd5, 8'd1);                      // one tick, no load while running
        rd_cnt(c);          chk("R7 no load running", c, 16'd99);
        wr(4'd14, 8'h00);                    // last tick on stop edge
        repeat (5) @(negedge clk);
        rd_cnt(c);          chk("R3 hold when stopped", c, 16'd98);
        wr(4'd5, 8'd0);
        rd_cnt(c);          chk("R7 reload after stop", c, 16'd100);
        wr(4'd4, 8'd7);
        rd_cnt(c);          chk("R7 low write no load", c, 16'd100);

        // R6 force load
        wr(4'd14, 8'h10);
        rd_cnt(c);          chk("R6 force load", c, 16'd7);
        rd(4'd14, r);       chk("R6 strobe reads 0", 16'(r), 16'h00);

        // R8 external edges: 5 pulses, each held 3 clocks
        wr(4'd14, 8'h21);
        for (int i = 0; i < 5; i++) begin
            cnt_in = 1'b1; repeat (3) @(negedge clk);
            cnt_in = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd_cnt(c);          chk("R8 external count", c, 16'd2);
        wr(4'd14, 8'h00);
        rd_cnt(c);          chk("R8 no clock count", c, 16'd2);

        // R6 combined load+start 0x19
        wr(4'd14, 8'h19);
        repeat (3) @(negedge clk);
        rd_cnt(c);          chk("R6 load and start", c, 16'd4);
        wr(4'd14, 8'h00);

        // R11 mask, R9 pin disabled
        wr(4'd4, 8'd2); wr(4'd5, 8'd0);
        rd_clr();
        wr(4'd13, 8'h00);
        wr(4'd14, 8'h01);
        repeat (7) @(negedge clk);
        rd(4'd13, r);       chk("R11 flag masked", 16'(r), 16'h01);
        chk("R11 irq masked", 16'(irq), 16'h0);
        chk("R9 pin disabled", 16'(tmr_pin), 16'h0);
        wr(4'd14, 8'h00);
        rd_clr();
        rd(4'd13, r);       chk("R11 read clears", 16'(r), 16'h00);

        // random trials in clock mode
        for (int t = 0; t < 150; t++) begin
            int          l, n, uf;
            bit          os, pm, p0;
            logic [1:0]  sp;
            logic [7:0]  cv, ev;
            l  = $urandom_range(0, 40);
            if ($urandom_range(0, 3) == 0) l += 16'h0100;
            n  = $urandom_range(0, 100);
            os = 1'($urandom_range(0, 1));
            pm = 1'($urandom_range(0, 1));
            sp = 2'($urandom_range(0, 3));
            wr(4'd14, 8'h02);
            wr(4'd4, 8'(l)); wr(4'd5, 8'(l >> 8));
            rd_clr();
            wr(4'd13, 8'h01);
            p0 = tmr_pin;
            cv = {sp, 2'b01, os, pm, 2'b11};
            wr(4'd14, cv);
            repeat (n) @(negedge clk);
            uf = exp_uf(l, n, os);
            rd_cnt(c);      chk("R2/R3/R4/R5 count", c, exp_cnt(l, n, os));
            rd(4'd13, r);   chk("R11 status", 16'(r), (uf > 0) ? 16'h81 : 16'h00);
            chk("R11 irq", 16'(irq), 16'(uf > 0));
            ev = {sp, 2'b00, os, pm, 1'b1, !(os && n > l)};
            rd(4'd14, r);   chk("R5/R12 ctrl readback", 16'(r), 16'(ev));
            if (pm) chk("R10 pulse pin", 16'(tmr_pin),
                        16'(os ? (n == l + 1) : (n > 0 && n % (l + 1) == 0)));
            else    chk("R9 toggle pin", 16'(tmr_pin), 16'(p0 ^ uf[0]));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule